// File: doc/BRIEF.md
# I2C Pin Timing and Spike Filter

This block sits between an I2C byte engine and the open-drain pins. On the receive side it cleans both bus lines. A glitch filter removes any pulse on SCL or SDA that lasts no longer than a programmable number of system clock cycles. A second stage then delays the SDA level handed to the receiver while SCL is high, which extends the time data is held at the sampling point.

On the transmit side it controls when pin changes reach the bus. A new SDA drive value from the engine is held back for a programmable number of cycles after every SCL falling edge. When the block serves a read as a slave transmitter, it keeps SCL pulled low for a programmable setup time after each SDA change.

All counts are in system clock cycles. They arrive as plain configuration inputs, so a register file elsewhere owns them.

Top module: `i2c_pin_timing`

## Requirements
- R1: After reset, `scl_filt`, `sda_filt` and `sda_rx` are 1. `sda_oe` is 0. `scl_oe` is 0 while `eng_scl_low` is 0.
- R2: With an effective spike limit L, a raw input pulse lasting L clock cycles or fewer never changes the matching filtered output.
- R3: A raw input that holds a new level for L+1 consecutive rising edges makes the filtered output take that level at the (L+1)th edge and not before.
- R4: A programmed spike limit `cfg_spike` of 0 behaves exactly like a limit of 1.
- R5: The SCL and SDA filters are independent: activity on one raw line never changes the other filtered output.
- R6: Let `scl_filt` go low at edge E0, with a transmit hold count H = `cfg_tx_hold`. Then `sda_oe` keeps its value through edge E0+H+1 and takes `eng_sda_low` at edge E0+H+2. This holds for H = 0 as well.
- R7: Outside a hold window, a change of `eng_sda_low` appears on `sda_oe` at the next rising edge. `sda_oe` = 1 means the pin is pulled low.
- R8: Let `sda_filt` change at edge E while `scl_filt` is high, with a receive hold count D = `cfg_rx_hold`. Then `sda_rx` follows at edge E+D+1 and not before.
- R9: While `scl_filt` is low, `sda_rx` takes the value of `sda_filt` at the next rising edge.
- R10: With `slv_tx` = 1, `sda_oe` changing at edge X holds `scl_oe` at 1 for exactly S = `cfg_setup` cycles, from X up to X+S-1. It is 0 again at X+S if `eng_scl_low` is 0. With `slv_tx` = 0, no stretch occurs.
- R11: `eng_scl_low` = 1 sets `scl_oe` to 1 in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_spike | input | 8 | Longest pulse length removed by the filters (0 acts as 1) |
| cfg_tx_hold | input | 16 | SDA transmit hold after SCL falls, in cycles |
| cfg_rx_hold | input | 8 | Receive-side SDA extension while SCL is high, in cycles |
| cfg_setup | input | 8 | SCL low stretch after an SDA change as slave transmitter |
| scl_raw | input | 1 | SCL pin level |
| sda_raw | input | 1 | SDA pin level |
| eng_sda_low | input | 1 | Engine request to pull SDA low |
| eng_scl_low | input | 1 | Engine request to pull SCL low |
| slv_tx | input | 1 | Engine is serving a read as slave transmitter |
| scl_filt | output | 1 | Filtered SCL |
| sda_filt | output | 1 | Filtered SDA |
| sda_rx | output | 1 | SDA level presented to the receiver |
| sda_oe | output | 1 | SDA pull-low enable after hold timing |
| scl_oe | output | 1 | SCL pull-low enable including setup stretch |

## Verification
The filters receive pulses exactly L cycles long and levels held for L+1 cycles. This separates a correct comparison against the limit from one that is off by one in either direction. The same pair is repeated with a limit of 0 to expose a missing floor. A transmit request is issued once with SCL high and once just after an SCL fall, with hold counts of 4 and 0. This tells the hold window apart from a plain register, and also checks where the window starts. An SDA change is applied with SCL high and again with SCL low, which separates the receive extension from simple pass-through. SDA changes are made with and without the slave-transmit flag, so the stretch is confirmed to start and end on the exact cycles.

// File: rtl/i2c_tm_pkg.sv
package i2c_tm_pkg;

  // Limit actually applied by the glitch filters: zero is raised to one.
  function automatic logic [7:0] spike_floor(input logic [7:0] lim);
    return (lim == 8'd0) ? 8'd1 : lim;
  endfunction

  // A settling counter has run long enough to let a new level through.
  function automatic logic settle_due(input logic [7:0] cnt, input logic [7:0] lim,
                                      input logic bypass);
    return bypass || (cnt >= lim);
  endfunction

endpackage

// File: rtl/i2c_settle.sv
module i2c_settle #(
  parameter int CNT_W = 8,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [CNT_W-1:0] lim,
  input  logic             bypass,
  output logic             dout
);
  import i2c_tm_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic             differs;
  logic             due;

  assign differs = (din != dout);
  assign due     = settle_due(8'(cnt), 8'(lim), bypass);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= RST_VAL;
      cnt  <= '0;
    end else if (!differs) begin
      cnt <= '0;
    end else if (due) begin
      dout <= din;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_tx_hold.sv
module i2c_tx_hold #(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_line,
  input  logic              req,
  input  logic [HOLD_W-1:0] hold_len,
  output logic              drive,
  output logic              fall,
  output logic              busy,
  output logic              upd
);
  logic              scl_q;
  logic [HOLD_W-1:0] cnt;

  assign fall = scl_q & ~scl_line;
  assign busy = fall | (cnt != '0);
  assign upd  = ~busy & (req != drive);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      cnt   <= '0;
      drive <= 1'b0;
    end else begin
      scl_q <= scl_line;
      if (fall)
        cnt <= hold_len;
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
      if (upd)
        drive <= req;
    end
  end
endmodule

// File: rtl/i2c_setup_stretch.sv
module i2c_setup_stretch #(
  parameter int SU_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [SU_W-1:0] setup_len,
  output logic            active
);
  logic [SU_W-1:0] cnt;

  assign active = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (start)
      cnt <= setup_len;
    else if (active)
      cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/i2c_pin_timing.sv
module i2c_pin_timing #(
  parameter int SPK_W  = 8,
  parameter int HOLD_W = 16,
  parameter int RXH_W  = 8,
  parameter int SU_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SPK_W-1:0]  cfg_spike,
  input  logic [HOLD_W-1:0] cfg_tx_hold,
  input  logic [RXH_W-1:0]  cfg_rx_hold,
  input  logic [SU_W-1:0]   cfg_setup,
  input  logic              scl_raw,
  input  logic              sda_raw,
  input  logic              eng_sda_low,
  input  logic              eng_scl_low,
  input  logic              slv_tx,
  output logic              scl_filt,
  output logic              sda_filt,
  output logic              sda_rx,
  output logic              sda_oe,
  output logic              scl_oe
);
  import i2c_tm_pkg::*;

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_vec;
  logic [NLINES-1:0] filt_vec;
  logic [SPK_W-1:0]  spike_eff;
  logic              scl_fall;
  logic              hold_busy;
  logic              sda_upd;
  logic              stretch;

  assign spike_eff = SPK_W'(spike_floor(8'(cfg_spike)));
  assign raw_vec   = {sda_raw, scl_raw};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2c_settle #(.CNT_W(SPK_W), .RST_VAL(1'b1)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (raw_vec[g]),
      .lim    (spike_eff),
      .bypass (1'b0),
      .dout   (filt_vec[g])
    );
  end

  assign scl_filt = filt_vec[0];
  assign sda_filt = filt_vec[1];

  // Receive extension: pass-through when SCL is low, delayed while high.
  i2c_settle #(.CNT_W(RXH_W), .RST_VAL(1'b1)) u_rx_ext (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (sda_filt),
    .lim    (cfg_rx_hold),
    .bypass (~scl_filt),
    .dout   (sda_rx)
  );

  i2c_tx_hold #(.HOLD_W(HOLD_W)) u_tx_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_line (scl_filt),
    .req      (eng_sda_low),
    .hold_len (cfg_tx_hold),
    .drive    (sda_oe),
    .fall     (scl_fall),
    .busy     (hold_busy),
    .upd      (sda_upd)
  );

  i2c_setup_stretch #(.SU_W(SU_W)) u_setup (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (sda_upd),
    .setup_len (cfg_setup),
    .active    (stretch)
  );

  assign scl_oe = eng_scl_low | (slv_tx & stretch);
endmodule

// File: rtl/i2c_pin_timing_chk.sv
module i2c_pin_timing_chk #(
  parameter int SU_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_raw,
  input logic            sda_raw,
  input logic            scl_filt,
  input logic            sda_filt,
  input logic            sda_rx,
  input logic            sda_oe,
  input logic            scl_oe,
  input logic            eng_scl_low,
  input logic            slv_tx,
  input logic [SU_W-1:0] cfg_setup,
  input logic            scl_fall,
  input logic            hold_busy
);
  // R3: a filtered line only moves to a level its raw input already had.
  p_scl_follows_raw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_filt != $past(scl_filt)) |-> ($past(scl_raw) == scl_filt));
  p_sda_follows_raw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_filt != $past(sda_filt)) |-> ($past(sda_raw) == sda_filt));
  // R6: the drive value is frozen on the edge after an SCL fall.
  p_hold_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |=> (sda_oe == $past(sda_oe)));
  // R6: a busy hold window never lets the drive value move.
  p_busy_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_busy |=> $stable(sda_oe));
  // R9: with SCL low the receiver sees SDA one edge later.
  p_rx_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_filt |=> (sda_rx == $past(sda_filt)));
  // R10: a drive change as slave transmitter starts a stretch.
  p_setup_stretch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_tx && (cfg_setup != '0) && (sda_oe != $past(sda_oe))) |-> scl_oe);
  // R11: the engine's SCL request always reaches the pin.
  p_scl_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_scl_low |-> scl_oe);
endmodule

bind i2c_pin_timing i2c_pin_timing_chk #(.SU_W(SU_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_raw     (scl_raw),
  .sda_raw     (sda_raw),
  .scl_filt    (scl_filt),
  .sda_filt    (sda_filt),
  .sda_rx      (sda_rx),
  .sda_oe      (sda_oe),
  .scl_oe      (scl_oe),
  .eng_scl_low (eng_scl_low),
  .slv_tx      (slv_tx),
  .cfg_setup   (cfg_setup),
  .scl_fall    (scl_fall),
  .hold_busy   (hold_busy)
);

// File: tb/i2c_pin_timing_tb.sv
module i2c_pin_timing_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_spike = 8'd3;
  logic [15:0] cfg_tx_hold = 16'd4;
  logic [7:0]  cfg_rx_hold = 8'd2;
  logic [7:0]  cfg_setup = 8'd5;
  logic        scl_raw = 1'b1, sda_raw = 1'b1;
  logic        eng_sda_low = 1'b0, eng_scl_low = 1'b0, slv_tx = 1'b0;
  logic        scl_filt, sda_filt, sda_rx, sda_oe, scl_oe;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  typedef struct { int at; int sig; logic val; string tag; } exp_t;
  exp_t sb[$];

  localparam int S_SCL = 0, S_SDA = 1, S_OE = 2, S_RX = 3, S_SCLOE = 4;

  i2c_pin_timing u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_spike(cfg_spike), .cfg_tx_hold(cfg_tx_hold),
    .cfg_rx_hold(cfg_rx_hold), .cfg_setup(cfg_setup), .scl_raw(scl_raw),
    .sda_raw(sda_raw), .eng_sda_low(eng_sda_low), .eng_scl_low(eng_scl_low),
    .slv_tx(slv_tx), .scl_filt(scl_filt), .sda_filt(sda_filt), .sda_rx(sda_rx),
    .sda_oe(sda_oe), .scl_oe(scl_oe)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic sig_val(input int s);
    case (s)
      S_SCL:   return scl_filt;
      S_SDA:   return sda_filt;
      S_OE:    return sda_oe;
      S_RX:    return sda_rx;
      default: return scl_oe;
    endcase
  endfunction

  task automatic expect_at(input int at, input int sig, input logic val, input string tag);
    exp_t e;
    e.at = at; e.sig = sig; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor: compare every expectation due in this cycle.
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        total++;
        if (sig_val(sb[i].sig) !== sb[i].val) begin
          bad++;
          $display("FAIL %s sig=%0d cyc=%0d actual=%b expected=%b",
                   sb[i].tag, sb[i].sig, cyc, sig_val(sb[i].sig), sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, e0, x;
    int L, H, D, S;
    L = 3; H = 4; D = 2; S = 5;
    step(3);
    rst_n = 1'b1;
    // R1 reset state
    expect_at(cyc, S_SCL, 1'b1, "R1");
    expect_at(cyc, S_SDA, 1'b1, "R1");
    expect_at(cyc, S_RX, 1'b1, "R1");
    expect_at(cyc, S_OE, 1'b0, "R1");
    expect_at(cyc, S_SCLOE, 1'b0, "R1");
    step(1);

    // R2: pulse of exactly L cycles is removed
    n = cyc; scl_raw = 1'b0;
    for (int k = 1; k <= L + 1; k++) expect_at(n + k, S_SCL, 1'b1, "R2");
    step(L); scl_raw = 1'b1;
    step(L + 3);

    // R3 and R8: SDA falls with SCL high
    n = cyc; sda_raw = 1'b0;
    expect_at(n + L, S_SDA, 1'b1, "R3");
    expect_at(n + L + 1, S_SDA, 1'b0, "R3");
    expect_at(n + L + 1 + D, S_RX, 1'b1, "R8");
    expect_at(n + L + D + 2, S_RX, 1'b0, "R8");
    step(L + D + 5);
    n = cyc; sda_raw = 1'b1;
    expect_at(n + L + 1, S_SDA, 1'b1, "R3");
    expect_at(n + L + D + 1, S_RX, 1'b0, "R8");
    expect_at(n + L + D + 2, S_RX, 1'b1, "R8");
    step(L + D + 5);

    // R7: request with SCL high passes after one edge; no stretch
    n = cyc; eng_sda_low = 1'b1;
    expect_at(n + 1, S_OE, 1'b1, "R7");
    expect_at(n + 1, S_SCLOE, 1'b0, "R10");
    step(3);

    // R6: request right after SCL fall is held H+1 edges
    n = cyc; scl_raw = 1'b0;
    e0 = n + L + 1;
    expect_at(e0, S_SCL, 1'b0, "R3");
    step(L + 1);
    eng_sda_low = 1'b0;
    expect_at(e0 + H + 1, S_OE, 1'b1, "R6");
    expect_at(e0 + H + 2, S_OE, 1'b0, "R6");
    step(H + 4);

    // R9: SDA change with SCL low reaches sda_rx one edge after sda_filt
    n = cyc; sda_raw = 1'b0;
    expect_at(n + L + 1, S_RX, 1'b1, "R9");
    expect_at(n + L + 2, S_RX, 1'b0, "R9");
    step(L + 4);

    // R10: slave-transmit stretch of S cycles
    slv_tx = 1'b1;
    n = cyc; eng_sda_low = 1'b1;
    x = n + 1;
    expect_at(x, S_OE, 1'b1, "R10");
    expect_at(x, S_SCLOE, 1'b1, "R10");
    expect_at(x + S - 1, S_SCLOE, 1'b1, "R10");
    expect_at(x + S, S_SCLOE, 1'b0, "R10");
    step(S + 3);

    // R11: engine SCL request is combinational
    eng_scl_low = 1'b1;
    expect_at(cyc, S_SCLOE, 1'b1, "R11");
    slv_tx = 1'b0;
    step(1);
    eng_scl_low = 1'b0;
    expect_at(cyc, S_SCLOE, 1'b0, "R11");
    step(2);

    // R4: limit 0 acts as 1; R5: SDA filter unaffected
    cfg_spike = 8'd0;
    step(1);
    n = cyc; scl_raw = 1'b1;
    step(1); scl_raw = 1'b0;
    expect_at(n + 1, S_SCL, 1'b0, "R4");
    expect_at(n + 2, S_SCL, 1'b0, "R4");
    step(3);
    n = cyc; scl_raw = 1'b1;
    expect_at(n + 1, S_SCL, 1'b0, "R4");
    expect_at(n + 2, S_SCL, 1'b1, "R4");
    expect_at(n + 2, S_SDA, 1'b0, "R5");
    step(4);

    // R6 with zero hold count
    cfg_tx_hold = 16'd0;
    n = cyc; scl_raw = 1'b0;
    e0 = n + 2;
    step(2);
    eng_sda_low = 1'b0;
    expect_at(e0 + 1, S_OE, 1'b1, "R6");
    expect_at(e0 + 2, S_OE, 1'b0, "R6");
    expect_at(e0 + 2, S_SCLOE, 1'b0, "R10");
    step(5);

    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard actual=%0d pending expected=0", sb.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule